// File: doc/BRIEF.md
# High-Bandwidth Isochronous IN Microframe Checker

This block watches one high-bandwidth isochronous IN endpoint over each microframe. During the microframe it counts three events: banks the CPU has handed over for transmission, packets that actually went out to the host, and IN tokens the host issued. On the microframe-boundary pulse it compares these counts with the configured number of transactions per microframe. A shortfall of validated banks, in a microframe where at least one packet left, sets a sticky error flag.

An underflow request tells the packet engine to answer with an automatic zero-length packet. It fires together with the error, but only when the host did issue enough IN tokens. A shortfall that comes from tokens the host never sent is not an underflow. An enable bit gates the sticky flag onto the endpoint interrupt line, and software clears the flag with a clear strobe.

Top module: `hbiso_in_mf_chk`

## Requirements
- R1: After reset, err_flag_o, udf_zlp_o and irq_o are all 0.
- R2: On a cycle with mf_tick_i=1, hb_iso_in_i=1 and ntrans_i in 1..3, the error flag is set from the next cycle on when the packets-sent count is at least 1 and the validated-bank count is less than ntrans_i. Example: ntrans_i=3 with two banks validated and packets sent sets the flag.
- R3: If no packet was sent in the closing microframe, no error is raised, whatever the validated-bank count.
- R4: If the validated-bank count is at least ntrans_i, no error is raised.
- R5: ntrans_i=0 or hb_iso_in_i=0 disables the check: a microframe boundary then never sets the flag.
- R6: When an error is raised and the IN-token count of the closing microframe is at least ntrans_i, udf_zlp_o is 1 for exactly the one cycle after the boundary. When the token count is below ntrans_i, udf_zlp_o stays 0.
- R7: err_flag_o stays set until err_clr_i is 1. A clear in the same cycle as a new error leaves the flag set.
- R8: irq_o is 1 exactly when err_flag_o is 1 and err_ie_i is 1.
- R9: The three counts restart from zero after each boundary. Strobes that arrive in the same cycle as mf_tick_i count toward the microframe that is closing.
- R10: Each count saturates at 3, so four strobes count as three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hb_iso_in_i | input | 1 | Endpoint is configured as high-bandwidth isochronous IN |
| ntrans_i | input | 2 | Transactions per microframe; 0 disables the check |
| mf_tick_i | input | 1 | One-cycle microframe boundary pulse |
| bank_valid_i | input | 1 | CPU validated one bank |
| pkt_sent_i | input | 1 | One packet was sent to the host |
| in_token_i | input | 1 | IN token received for this endpoint |
| err_ie_i | input | 1 | Interrupt enable for the error flag |
| err_clr_i | input | 1 | Clears the sticky error flag |
| err_flag_o | output | 1 | Sticky microframe shortfall flag |
| udf_zlp_o | output | 1 | One-cycle underflow request with zero-length packet |
| irq_o | output | 1 | Endpoint interrupt |

## Verification
The bench goes after the boundary between a count that is just short of ntrans_i and one that meets it. A comparison off by one would either miss the three-versus-two shortfall or flag a complete microframe. It also checks a microframe with no packet sent and a large bank shortfall, where a design that ignores the packet count would raise a false error. The token-shortfall cases catch a design that raises the zero-length-packet request for tokens that never came. The counter-restart and same-cycle-strobe cases catch counts that leak across boundaries or lose the last strobe. Set-over-clear and the saturation cases catch a lost error and a count that wraps back to zero.

// File: rtl/hbiso_pkg.sv
package hbiso_pkg;
  localparam int unsigned NT_W = 2;
  localparam int unsigned N_EV = 3;
  typedef enum logic [1:0] {
    EV_BANK = 2'd0,
    EV_PKT  = 2'd1,
    EV_TOK  = 2'd2
  } ev_e;
  typedef logic [NT_W-1:0] cnt_t;
endpackage

// File: rtl/hbiso_mf_cnt.sv
module hbiso_mf_cnt #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         tick_i,
  output logic [W-1:0] cur_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  // count including this cycle's strobe, saturating
  always_comb begin
    cur_o = cnt_q;
    if (inc_i && cnt_q != MAX) cur_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= '0;
    else             cnt_q <= cur_o;
  end

  a_r10_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !tick_i) |=> cnt_q == MAX);
  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == '0);
endmodule

// File: rtl/hbiso_mf_judge.sv
module hbiso_mf_judge
  import hbiso_pkg::*;
(
  input  logic tick_i,
  input  logic hb_iso_in_i,
  input  cnt_t ntrans_i,
  input  cnt_t bank_i,
  input  cnt_t pkt_i,
  input  cnt_t tok_i,
  output logic err_evt_o,
  output logic udf_evt_o
);
  logic active;

  always_comb begin
    active    = tick_i && hb_iso_in_i && (ntrans_i != '0);
    err_evt_o = active && (pkt_i != '0) && (bank_i < ntrans_i);
    // a missing IN token explains the gap: no underflow
    udf_evt_o = err_evt_o && (tok_i >= ntrans_i);
  end
endmodule

// File: rtl/hbiso_err_flag.sv
module hbiso_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_evt_i,
  input  logic udf_evt_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic udf_o,
  output logic irq_o
);
  logic flag_q, udf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      udf_q <= udf_evt_i;
      if (err_evt_i)  flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign udf_o  = udf_q;
  assign irq_o  = flag_q & ie_i;

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |=> flag_q);
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_q |=> !udf_q);
  a_r6_udf_with_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_q |-> flag_q);
endmodule

// File: rtl/hbiso_in_mf_chk.sv
module hbiso_in_mf_chk
  import hbiso_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hb_iso_in_i,
  input  logic [NT_W-1:0] ntrans_i,
  input  logic            mf_tick_i,
  input  logic            bank_valid_i,
  input  logic            pkt_sent_i,
  input  logic            in_token_i,
  input  logic            err_ie_i,
  input  logic            err_clr_i,
  output logic            err_flag_o,
  output logic            udf_zlp_o,
  output logic            irq_o
);
  logic [N_EV-1:0] ev_inc;
  cnt_t            ev_cnt [N_EV];
  logic            err_evt, udf_evt;

  assign ev_inc[EV_BANK] = bank_valid_i;
  assign ev_inc[EV_PKT]  = pkt_sent_i;
  assign ev_inc[EV_TOK]  = in_token_i;

  for (genvar g = 0; g < N_EV; g++) begin : g_cnt
    hbiso_mf_cnt #(.W(NT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (ev_inc[g]),
      .tick_i (mf_tick_i),
      .cur_o  (ev_cnt[g])
    );
  end

  hbiso_mf_judge u_judge (
    .tick_i      (mf_tick_i),
    .hb_iso_in_i (hb_iso_in_i),
    .ntrans_i    (ntrans_i),
    .bank_i      (ev_cnt[EV_BANK]),
    .pkt_i       (ev_cnt[EV_PKT]),
    .tok_i       (ev_cnt[EV_TOK]),
    .err_evt_o   (err_evt),
    .udf_evt_o   (udf_evt)
  );

  hbiso_err_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_evt_i (err_evt),
    .udf_evt_i (udf_evt),
    .clr_i     (err_clr_i),
    .ie_i      (err_ie_i),
    .flag_o    (err_flag_o),
    .udf_o     (udf_zlp_o),
    .irq_o     (irq_o)
  );

  a_r2_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_flag_o && !mf_tick_i |=> !err_flag_o);
  a_r5_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_flag_o && (ntrans_i == '0 || !hb_iso_in_i)) |=> !err_flag_o);
  a_r8_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (err_flag_o && err_ie_i));
  a_r3_no_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_flag_o && !pkt_sent_i && mf_tick_i && ev_cnt[EV_PKT] == '0) |=> !err_flag_o);
endmodule

// File: tb/sim_hbiso_in_mf_chk.sv
module sim_hbiso_in_mf_chk;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hb = 1'b0, tick = 1'b0, bank = 1'b0, pkt = 1'b0, tok = 1'b0;
  logic ie = 1'b0, clr = 1'b0;
  logic [1:0] nt = 2'd0;
  logic err, udf, irq;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  hbiso_in_mf_chk u0 (
    .clk_i(clk), .rst_ni(rst_n), .hb_iso_in_i(hb), .ntrans_i(nt),
    .mf_tick_i(tick), .bank_valid_i(bank), .pkt_sent_i(pkt), .in_token_i(tok),
    .err_ie_i(ie), .err_clr_i(clr), .err_flag_o(err), .udf_zlp_o(udf), .irq_o(irq)
  );

  // {hb, nt[1:0], banks[2:0], pkts[2:0], toks[2:0], exp_err, exp_udf}
  function automatic logic [13:0] mk(int h, int n, int b, int p, int t, int e, int u);
    return {h[0], n[1:0], b[2:0], p[2:0], t[2:0], e[0], u[0]};
  endfunction

  localparam int NV = 10;
  localparam logic [13:0] VEC [NV] = '{
    mk(1, 3, 2, 2, 3, 1, 1),  // R2 R6 three wanted, two banks
    mk(1, 3, 2, 2, 2, 1, 0),  // R6 token missing
    mk(1, 3, 3, 3, 3, 0, 0),  // R4 complete
    mk(1, 2, 1, 0, 0, 0, 0),  // R3 nothing sent
    mk(1, 0, 0, 1, 1, 0, 0),  // R5 ntrans 0
    mk(0, 3, 0, 1, 3, 0, 0),  // R5 not hb iso in
    mk(1, 1, 0, 1, 1, 1, 1),  // R2 single transaction
    mk(1, 2, 4, 1, 1, 0, 0),  // R10 bank saturates, still enough
    mk(1, 2, 0, 1, 1, 1, 0),  // R6 one token of two
    mk(1, 3, 0, 4, 4, 1, 1)   // R10 token saturates at 3
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  // drive strobes then a boundary; returns just after the boundary edge
  task automatic frame(logic h, logic [1:0] n, int b, int p, int t, logic pkt_on_tick);
    int m;
    hb = h; nt = n;
    m = b; if (p > m) m = p; if (t > m) m = t;
    for (int i = 0; i < m; i++) begin
      bank = (i < b); pkt = (i < p); tok = (i < t);
      @(negedge clk);
    end
    bank = 1'b0; tok = 1'b0; pkt = pkt_on_tick; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; pkt = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 flag", err, 1'b0);
    chk("R1 udf", udf, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      do_clr();
      frame(VEC[v][13], VEC[v][12:11], int'(VEC[v][10:8]), int'(VEC[v][7:5]),
            int'(VEC[v][4:2]), 1'b0);
      chk($sformatf("R2/R3/R4/R5 vec%0d err", v), err, VEC[v][1]);
      chk($sformatf("R6 vec%0d udf", v), udf, VEC[v][0]);
      @(negedge clk);
      chk($sformatf("R6 vec%0d udf one cycle", v), udf, 1'b0);
    end

    // R8 irq gating
    do_clr();
    frame(1'b1, 2'd3, 2, 2, 3, 1'b0);
    ie = 1'b0; #1; chk("R8 irq masked", irq, 1'b0);
    ie = 1'b1; #1; chk("R8 irq enabled", irq, 1'b1);
    // R7 sticky across a clean frame
    frame(1'b1, 2'd3, 3, 3, 3, 1'b0);
    chk("R7 sticky", err, 1'b1);
    do_clr();
    chk("R7 cleared", err, 1'b0);
    chk("R8 irq follows clear", irq, 1'b0);
    ie = 1'b0;

    // R7 set wins over clear in the same cycle
    hb = 1'b1; nt = 2'd2; pkt = 1'b1; @(negedge clk); pkt = 1'b0;
    tick = 1'b1; clr = 1'b1; @(negedge clk); tick = 1'b0; clr = 1'b0;
    chk("R7 set over clear", err, 1'b1);

    // R9 counts restart: full frame then frame with no banks
    do_clr();
    frame(1'b1, 2'd3, 3, 0, 0, 1'b0);
    chk("R9 first frame clean", err, 1'b0);
    frame(1'b1, 2'd3, 0, 1, 3, 1'b0);
    chk("R9 banks not carried", err, 1'b1);

    // R9 packet strobe in the boundary cycle counts toward the closing frame
    do_clr();
    frame(1'b1, 2'd1, 0, 0, 0, 1'b1);
    chk("R9 same-cycle packet", err, 1'b1);
    do_clr();
    frame(1'b1, 2'd1, 0, 0, 0, 1'b0);
    chk("R9 tick packet not carried", err, 1'b0);

    summary();
  end
endmodule